// File: doc/BRIEF.md
# CPI-Driven Operating-Point Governor

This block watches how efficiently a processor core runs and decides, once per time slice, whether the core's operating point (supply voltage and clock rate together) should move up one step, move down one step, or stay where it is. During the counting phase of each slice it counts elapsed core clocks and retired instructions. It then freezes both counters and compares the cycles-per-instruction ratio against a programmable dead band. A ratio below the lower bound means the core is compute-bound and would benefit from a faster clock. A ratio above the upper bound means the core is mostly stalled on the bus and can run slower at lower voltage.

The resulting request is a single-cycle pulse with a direction bit, sent to a separate transition sequencer that performs the actual voltage and clock moves. The governor keeps its own record of the current level so that it never asks to step past either end of the range. While the sequencer reports busy, decisions are dropped, but the slice timer keeps running. Both thresholds are unsigned fixed-point values with 4 fractional bits. The ratio is tested without a divider: the cycle count, scaled by 16, is compared against the threshold multiplied by the instruction count.

The controller has three named states. COUNT counts clocks and retirements. FREEZE holds the counters and registers the comparison result. DECIDE issues or drops the request and clears the counters. The transitions are slice_end (COUNT to FREEZE, taken after the last counting cycle), sampled (FREEZE to DECIDE, always) and restart (DECIDE to COUNT, always).

Top module: `cpi_governor`

## Requirements
- R1: A slice has `slice_len_i` counting cycles (a value of 0 acts as 1) plus one FREEZE cycle and one DECIDE cycle, so under steady conditions consecutive requests are exactly `slice_len_i + 2` clocks apart.
- R2: Both counters hold their values during FREEZE and DECIDE, a retire strobe in those cycles is not counted, and both counters restart from zero in the next slice.
- R3: With a nonzero instruction count, when cycles×16 < `cpi_lo_i`×instructions, the decision is a step up. This test takes priority over R4.
- R4: With a nonzero instruction count, when cycles×16 > `cpi_hi_i`×instructions, the decision is a step down.
- R5: When neither R3 nor R4 applies (a ratio equal to a threshold counts as inside the band), no request is issued.
- R6: A slice that retires no instructions produces a step-down decision.
- R7: A request is `step_req_o` high for exactly one clock, in the first cycle of the following slice. `step_up_o` is 1 for up and 0 for down. At most one request is issued per slice.
- R8: The internal level runs from 0 to NUM_LEVELS-1 and resets to RESET_LEVEL. A step up at the top or a step down at the bottom is suppressed, and every issued request moves the level by one.
- R9: If `seq_busy_i` is high in the DECIDE cycle, that slice's decision is discarded and the slice timer is unaffected.
- R10: After reset, `step_req_o` and `step_up_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction retired this cycle |
| cpi_lo_i | input | TH_W | Lower CPI bound, 4 fractional bits |
| cpi_hi_i | input | TH_W | Upper CPI bound, 4 fractional bits |
| slice_len_i | input | CNT_W | Counting cycles per slice (0 acts as 1) |
| seq_busy_i | input | 1 | Transition sequencer is busy |
| step_req_o | output | 1 | One-cycle step request pulse |
| step_up_o | output | 1 | Direction of the request: 1 = up, 0 = down |

## Verification
The bench goes after the exact band edges. A CPI of exactly 1.0 against a lower bound of 1.0, and exactly 2.0 against a lower bound of 2.0, must both hold. A design using an inclusive comparison, or one that also counted retirements during the freeze cycles, would step up instead. It drives a slice with zero retirements to confirm a step down rather than a hold, and it drives the level into both ends of the range so that a design without limit checks would keep requesting. Finally, it holds the sequencer busy over several slices, where a design that queued the decision would issue a late request, and it measures the spacing between requests to catch an off-by-one slice length.

// File: rtl/gov_pkg.sv
package gov_pkg;
    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,
        DEC_UP   = 2'd1,
        DEC_DOWN = 2'd2
    } gov_dec_e;

    typedef enum logic [1:0] {
        S_COUNT  = 2'd0,
        S_FREEZE = 2'd1,
        S_DECIDE = 2'd2
    } gov_state_e;

    localparam int FRAC_BITS = 4;
endpackage

// File: rtl/gov_counters.sv
module gov_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             retire_i,
    output logic [CNT_W-1:0] cyc_o,
    output logic [CNT_W-1:0] ins_o
);
    logic [CNT_W-1:0] cyc_q, ins_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            ins_q <= '0;
        end else if (clr_i) begin
            cyc_q <= '0;
            ins_q <= '0;
        end else if (en_i) begin
            cyc_q <= cyc_q + 1'b1;
            if (retire_i) ins_q <= ins_q + 1'b1;
        end
    end

    assign cyc_o = cyc_q;
    assign ins_o = ins_q;

    // R2: counts frozen while sampling
    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> ($stable(cyc_o) && $stable(ins_o)));
    // R2: cleared for the next slice
    a_r2_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cyc_o == '0 && ins_o == '0));
endmodule

// File: rtl/gov_cpi_cmp.sv
module gov_cpi_cmp
    import gov_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int TH_W  = 8
) (
    input  logic [CNT_W-1:0] cyc_i,
    input  logic [CNT_W-1:0] ins_i,
    input  logic [TH_W-1:0]  lo_i,
    input  logic [TH_W-1:0]  hi_i,
    output gov_dec_e         dec_o
);
    localparam int PW = CNT_W + TH_W;

    logic [PW-1:0] scaled_cyc, lo_prod, hi_prod;

    always_comb begin
        scaled_cyc = PW'(cyc_i) << FRAC_BITS;
        lo_prod    = PW'(lo_i) * PW'(ins_i);
        hi_prod    = PW'(hi_i) * PW'(ins_i);
        if (ins_i == '0)
            dec_o = DEC_DOWN;
        else if (scaled_cyc < lo_prod)
            dec_o = DEC_UP;
        else if (scaled_cyc > hi_prod)
            dec_o = DEC_DOWN;
        else
            dec_o = DEC_HOLD;
    end
endmodule

// File: rtl/gov_level.sv
module gov_level #(
    parameter int NUM_LEVELS  = 8,
    parameter int RESET_LEVEL = NUM_LEVELS - 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic at_top_o,
    output logic at_bot_o
);
    localparam int LVL_W = (NUM_LEVELS > 2) ? $clog2(NUM_LEVELS) : 1;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LEVELS - 1);
    localparam logic [LVL_W-1:0] RST_LVL = LVL_W'(RESET_LEVEL);

    logic [LVL_W-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lvl_q <= RST_LVL;
        else if (inc_i)
            lvl_q <= lvl_q + 1'b1;
        else if (dec_i)
            lvl_q <= lvl_q - 1'b1;
    end

    assign at_top_o = (lvl_q == TOP_LVL);
    assign at_bot_o = (lvl_q == '0);

    // R8: never step past either end
    a_r8_no_inc_top: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> (lvl_q != TOP_LVL));
    a_r8_no_dec_bot: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (lvl_q != '0));
    a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= TOP_LVL);
endmodule

// File: rtl/cpi_governor.sv
module cpi_governor
    import gov_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TH_W        = 8,
    parameter int NUM_LEVELS  = 8,
    parameter int RESET_LEVEL = NUM_LEVELS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic [TH_W-1:0]  cpi_lo_i,
    input  logic [TH_W-1:0]  cpi_hi_i,
    input  logic [CNT_W-1:0] slice_len_i,
    input  logic             seq_busy_i,
    output logic             step_req_o,
    output logic             step_up_o
);
    gov_state_e       state_q, state_d;
    gov_dec_e         dec_now, dec_q;
    logic [CNT_W-1:0] cyc_cnt, ins_cnt;
    logic             cnt_en, cnt_clr, slice_end;
    logic             at_top, at_bot, fire_up, fire_dn;
    logic             req_q, up_q;

    assign cnt_en    = (state_q == S_COUNT);
    assign cnt_clr   = (state_q == S_DECIDE);
    assign slice_end = cnt_en &&
        (({1'b0, cyc_cnt} + 1'b1) >= {1'b0, slice_len_i});

    gov_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cnt_en),
        .clr_i    (cnt_clr),
        .retire_i (retire_i),
        .cyc_o    (cyc_cnt),
        .ins_o    (ins_cnt)
    );

    gov_cpi_cmp #(.CNT_W(CNT_W), .TH_W(TH_W)) u_cmp (
        .cyc_i (cyc_cnt),
        .ins_i (ins_cnt),
        .lo_i  (cpi_lo_i),
        .hi_i  (cpi_hi_i),
        .dec_o (dec_now)
    );

    gov_level #(.NUM_LEVELS(NUM_LEVELS), .RESET_LEVEL(RESET_LEVEL)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (fire_up),
        .dec_i    (fire_dn),
        .at_top_o (at_top),
        .at_bot_o (at_bot)
    );

    // next-state logic: slice_end, sampled, restart
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_COUNT:  if (slice_end) state_d = S_FREEZE;
            S_FREEZE: state_d = S_DECIDE;
            S_DECIDE: state_d = S_COUNT;
            default:  state_d = S_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_COUNT;
            dec_q   <= DEC_HOLD;
        end else begin
            state_q <= state_d;
            if (state_q == S_FREEZE) dec_q <= dec_now;
        end
    end

    assign fire_up = (state_q == S_DECIDE) && !seq_busy_i &&
                     (dec_q == DEC_UP) && !at_top;
    assign fire_dn = (state_q == S_DECIDE) && !seq_busy_i &&
                     (dec_q == DEC_DOWN) && !at_bot;

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            up_q  <= 1'b0;
        end else begin
            req_q <= fire_up || fire_dn;
            if (fire_up || fire_dn) up_q <= fire_up;
        end
    end

    assign step_req_o = req_q;
    assign step_up_o  = up_q;

    // R7: request is a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        step_req_o |=> !step_req_o);
    // R9: busy at decision time drops the request
    a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECIDE && seq_busy_i) |=> !step_req_o);
    // R1: one decision per slice, then counting resumes
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DECIDE) |=> (state_q == S_COUNT));
    // R7: a request only follows a decision cycle
    a_r7_after_decide: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_req_o) |-> ($past(state_q) == S_DECIDE));
endmodule

// File: tb/sim_cpi_governor.sv
module sim_cpi_governor;
    localparam int CNT_W = 16;
    localparam int TH_W  = 8;
    localparam int SLEN  = 32;
    localparam int SPER  = SLEN + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             retire = 1'b0;
    logic [TH_W-1:0]  cpi_lo = 8'h20;
    logic [TH_W-1:0]  cpi_hi = 8'h30;
    logic [CNT_W-1:0] slice_len = CNT_W'(SLEN);
    logic             busy = 1'b0;
    logic             step_req, step_up;

    int checks = 0;
    int errors = 0;
    int period = 0;       // 0: never retire, N: retire every Nth cycle
    int phase  = 0;
    int n_up = 0, n_dn = 0;
    int cyc = 0, last_pulse = -1, prev_pulse = -1;
    bit done = 0;

    always #10 clk = ~clk;

    cpi_governor u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire_i    (retire),
        .cpi_lo_i    (cpi_lo),
        .cpi_hi_i    (cpi_hi),
        .slice_len_i (slice_len),
        .seq_busy_i  (busy),
        .step_req_o  (step_req),
        .step_up_o   (step_up)
    );

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // retire pattern driver and request monitor
    initial forever begin
        @(negedge clk);
        if (rst_n && step_req) begin
            if (step_up) n_up++; else n_dn++;
            prev_pulse = last_pulse;
            last_pulse = cyc;
        end
        if (period == 0) retire = 1'b0;
        else begin
            retire = (phase == 0);
            phase  = (phase + 1 >= period) ? 0 : phase + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic slices(input int k);
        repeat (k * SPER) @(posedge clk);
    endtask

    // flush two slices, then count requests over a window of k slices
    task automatic window(input int k, output int ups, output int dns);
        slices(2);
        n_up = 0; n_dn = 0;
        slices(k);
        ups = n_up; dns = n_dn;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 step_req after reset", int'(step_req), 0);
        check("R10 step_up after reset", int'(step_up), 0);
    endtask

    task automatic t_zero_retire();
        int u, d;
        period = 0;
        window(3, u, d);
        check("R6 zero-retire downs", d, 3);
        check("R6 zero-retire ups", u, 0);
        check("R1 request spacing", last_pulse - prev_pulse, SPER);
        slices(6);
        window(3, u, d);
        check("R8 bottom limit suppresses down", d + u, 0);
    endtask

    task automatic t_compute_bound();
        int u, d;
        cpi_lo = 8'h20; period = 1;
        window(3, u, d);
        check("R3 CPI 1.0 below 2.0 gives ups", u, 3);
        check("R7 no down while compute-bound", d, 0);
    endtask

    task automatic t_freeze_edge();
        int u, d;
        cpi_lo = 8'h10; period = 1;
        window(3, u, d);
        check("R2 CPI exactly 1.0 at lower bound holds", u + d, 0);
    endtask

    task automatic t_hold_band();
        int u, d;
        cpi_lo = 8'h20; cpi_hi = 8'h30; period = 2;
        window(3, u, d);
        check("R5 CPI 2.0 inside band holds", u + d, 0);
    endtask

    task automatic t_bus_bound();
        int u, d;
        period = 4;
        window(3, u, d);
        check("R4 CPI 4.0 above 3.0 gives downs", d, 3);
        check("R4 no up while bus-bound", u, 0);
    endtask

    task automatic t_busy();
        int u, d;
        period = 1; busy = 1'b1;
        window(3, u, d);
        check("R9 busy discards decisions", u + d, 0);
        busy = 1'b0;
        window(3, u, d);
        check("R9 requests resume after busy", u, 3);
    endtask

    task automatic t_top();
        int u, d;
        period = 1;
        slices(8);
        window(3, u, d);
        check("R8 top limit suppresses up", u + d, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_zero_retire();
        t_compute_bound();
        t_freeze_edge();
        t_hold_band();
        t_bus_bound();
        t_busy();
        t_top();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule